// File: doc/BRIEF.md
# Shared-Clock Tick Fan-out Controller

This block spreads the system tick of a time-triggered multi-node design over point-to-point links, so that no shared broadcast bus is needed. In a master node, an overflow of the local timer opens a tick cycle. The block raises a one-cycle interrupt pulse to the local processor. It then hands the tick to every link selected in a configuration bitmask, and it collects one acknowledgement from each slave on that link. Two master dispatch styles exist. In stop-and-wait, a link is not served until the previous link has acknowledged or timed out. In round-robin, all links are served back to back and the acknowledgements are gathered afterwards.

In a relay node, a tick that arrives on the parent link raises the same local interrupt pulse. The tick is then offered at once to every child link in the mask, so a node only ever handles its direct neighbours. Relay mode collects no acknowledgements. Each tick-out is a valid/ready handshake per link. A late or missing acknowledgement sets a sticky per-link error bit, and dispatch continues. A new tick event that arrives while a dispatch is still running is dropped and sets a sticky overrun flag.

Top module: `tick_fanout_ctrl`

## Requirements
- R1: After reset, busy, local_tick, overrun, every link_err bit and every tick_out_valid bit are 0.
- R2: With mode[1]=0 (master), a timer_ovf pulse seen while idle gives local_tick=1 for exactly one cycle, on the clock after the pulse. Dispatch to link_mask then begins. parent_tick is ignored in master modes.
- R3: With mode[1]=1 (relay), a parent_tick pulse seen while idle gives one local_tick pulse, and tick_out_valid equals link_mask in the very next cycle. No acknowledgement is awaited and no link_err bit is set. timer_ovf is ignored in relay mode.
- R4: In master modes, each link in link_mask gets exactly one handshake per tick, and the handshakes occur in increasing link index order.
- R5: A raised tick_out_valid bit stays high, unchanged, until the cycle in which its tick_out_ready bit is 1. That cycle completes the handshake, and the bit then drops.
- R6: mode=0 (stop-and-wait): no handshake is offered to a link while an earlier link still awaits its acknowledgement, so at most one link is outstanding.
- R7: mode=1 (round-robin): all masked links are served without waiting for acknowledgements, so all of them can be outstanding at once.
- R8: An ack_in bit is accepted if it arrives in one of the first ack_timeout+1 cycles after waiting begins. Waiting begins after the link's handshake in stop-and-wait, and after the last handshake in round-robin. If no acknowledgement arrives in that window, the link's link_err bit is set and dispatch moves on.
- R9: A tick event that arrives while busy=1 is dropped, not queued, and sets overrun. overrun stays 1 until reset.
- R10: link_err bits stay set until reset, even across later error-free dispatches. A tick with link_mask=0 still pulses local_tick but never raises busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 stop-and-wait, 1 round-robin, 2 or 3 tree relay; latched when a tick starts |
| link_mask | input | LINKS | Links served per tick (slaves or children) |
| ack_timeout | input | TW | Extra wait cycles allowed for an acknowledgement |
| timer_ovf | input | 1 | Local timer overflow pulse (master trigger) |
| parent_tick | input | 1 | Tick received on the parent link (relay trigger) |
| tick_out_ready | input | LINKS | Per-link acceptance of a tick |
| ack_in | input | LINKS | Per-link acknowledgement pulse |
| tick_out_valid | output | LINKS | Per-link tick offer |
| local_tick | output | 1 | One-cycle interrupt pulse to the local processor |
| busy | output | 1 | Dispatch in progress |
| overrun | output | 1 | Sticky: a tick was dropped while busy |
| link_err | output | LINKS | Sticky per-link missing-acknowledgement flags |

## Verification
A table walks the three dispatch styles against sparse, dense and empty link masks. Each run uses its own acknowledgement delay and a set of silent links. Delay equal to the timeout versus one cycle beyond it separates an accepted acknowledgement from an error. The peak count of outstanding links separates stop-and-wait from round-robin, and the width of the first offer separates relay from both master styles. Directed cases hold ready low, send the other mode's trigger, raise a second overflow mid-dispatch, and repeat a dispatch without reset to show that the flags are sticky.

// File: rtl/tick_fanout_ctrl.sv
module tick_fanout_ctrl #(
  parameter int LINKS = 4,
  parameter int TW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [LINKS-1:0] link_mask,
  input  logic [TW-1:0]    ack_timeout,
  input  logic             timer_ovf,
  input  logic             parent_tick,
  input  logic [LINKS-1:0] tick_out_ready,
  input  logic [LINKS-1:0] ack_in,
  output logic [LINKS-1:0] tick_out_valid,
  output logic             local_tick,
  output logic             busy,
  output logic             overrun,
  output logic [LINKS-1:0] link_err
);

  logic [LINKS-1:0] pend, outst, sel, hs;
  logic [TW-1:0]    cnt;
  logic             relay_q, sw_q;

  wire ev      = mode[1] ? parent_tick : timer_ovf;
  wire waiting = (|outst) && (sw_q || pend == '0);
  wire expire  = waiting && (cnt == ack_timeout);

  assign busy = (|pend) || (|outst);
  assign sel  = pend & (~pend + 1'b1);
  assign tick_out_valid = relay_q ? pend : ((sw_q && |outst) ? '0 : sel);
  assign hs   = tick_out_valid & tick_out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= '0;
      outst      <= '0;
      cnt        <= '0;
      relay_q    <= 1'b0;
      sw_q       <= 1'b0;
      local_tick <= 1'b0;
      overrun    <= 1'b0;
      link_err   <= '0;
    end else begin
      local_tick <= 1'b0;
      if (ev) begin
        if (busy) begin
          overrun <= 1'b1;
        end else begin
          local_tick <= 1'b1;
          pend       <= link_mask;
          relay_q    <= mode[1];
          sw_q       <= (mode == 2'd0);
          cnt        <= '0;
        end
      end
      if (busy) begin
        pend <= pend & ~hs;
        if (expire) begin
          link_err <= link_err | (outst & ~ack_in);
          outst    <= '0;
        end else begin
          outst <= (outst & ~ack_in) | (relay_q ? '0 : hs);
        end
        if (|hs)         cnt <= '0;
        else if (waiting) cnt <= cnt + 1'b1;
      end
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !overrun && link_err == '0));

  // R2
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    local_tick |-> !$past(busy));

  // R5
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(tick_out_valid & ~tick_out_ready)) |=>
      ((tick_out_valid & $past(tick_out_valid & ~tick_out_ready))
        == $past(tick_out_valid & ~tick_out_ready)));

  // R6
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_q |-> ($countones(outst) <= 1));

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R9
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(busy));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((link_err & $past(link_err)) == $past(link_err)));

endmodule

// File: tb/tick_fanout_ctrl_tb_top.sv
module tick_fanout_ctrl_tb_top;
  localparam int L = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = '0;
  logic [L-1:0] link_mask = '0, rdy = '1, ack_in = '0;
  logic [7:0] ack_timeout = 8'd4;
  logic timer_ovf = 1'b0, parent_tick = 1'b0;
  logic [L-1:0] tick_out_valid, link_err;
  logic local_tick, busy, overrun;

  tick_fanout_ctrl #(.LINKS(L), .TW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .link_mask(link_mask),
    .ack_timeout(ack_timeout), .timer_ovf(timer_ovf), .parent_tick(parent_tick),
    .tick_out_ready(rdy), .ack_in(ack_in), .tick_out_valid(tick_out_valid),
    .local_tick(local_tick), .busy(busy), .overrun(overrun), .link_err(link_err));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int dly = 0;
  logic [L-1:0] noack = '0, hs_acc = '0, out_b = '0;
  int cd [L];
  int ltick_cnt = 0, hs_cnt = 0, max_out = 0, first_cnt = -1, last_idx = -1;
  bit order_ok = 1'b1;

  // vector: mode, mask, timeout, ack delay, silent links, expected link_err
  localparam logic [29:0] VEC [0:7] = '{
    {2'd0, 4'b1011, 8'd5, 8'd0, 4'b0000, 4'b0000},
    {2'd0, 4'b0110, 8'd4, 8'd4, 4'b0000, 4'b0000},
    {2'd0, 4'b0110, 8'd4, 8'd5, 4'b0000, 4'b0110},
    {2'd0, 4'b1111, 8'd3, 8'd1, 4'b0100, 4'b0100},
    {2'd1, 4'b1111, 8'd6, 8'd4, 4'b0000, 4'b0000},
    {2'd1, 4'b1101, 8'd6, 8'd2, 4'b1000, 4'b1000},
    {2'd2, 4'b0101, 8'd2, 8'd0, 4'b0101, 4'b0000},
    {2'd0, 4'b0000, 8'd3, 8'd0, 4'b0000, 4'b0000}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_rec();
    hs_acc = '0; out_b = '0; ltick_cnt = 0; hs_cnt = 0; max_out = 0;
    first_cnt = -1; last_idx = -1; order_ok = 1'b1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; timer_ovf = 1'b0; parent_tick = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse(input bit relay_trig);
    @(negedge clk);
    if (relay_trig) parent_tick = 1'b1; else timer_ovf = 1'b1;
    @(negedge clk);
    parent_tick = 1'b0; timer_ovf = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  // responder and monitor, sampling between the negative edge and the next rising edge
  initial begin
    for (int i = 0; i < L; i++) cd[i] = 0;
    forever begin
      @(posedge clk); #15;
      if (local_tick) ltick_cnt++;
      if (first_cnt < 0 && tick_out_valid != '0) first_cnt = $countones(tick_out_valid);
      ack_in = '0;
      for (int i = 0; i < L; i++) begin
        if (cd[i] == 1) begin ack_in[i] = 1'b1; out_b[i] = 1'b0; end
        if (cd[i] > 0) cd[i]--;
        if (tick_out_valid[i] && rdy[i]) begin
          hs_acc[i] = 1'b1; hs_cnt++;
          if (i <= last_idx) order_ok = 1'b0;
          last_idx = i;
          if (!noack[i]) begin cd[i] = dly + 1; out_b[i] = 1'b1; end
        end
      end
      if ($countones(out_b) > max_out) max_out = $countones(out_b);
    end
  end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0] m;
    logic [3:0] mk, na, ee;
    do_reset();
    chk(busy == 0 && overrun == 0 && link_err == 0 && tick_out_valid == 0 && local_tick == 0,
        "R1 reset state", {busy, overrun, link_err, tick_out_valid}, 0);

    for (int v = 0; v < 8; v++) begin
      m = VEC[v][29:28]; mk = VEC[v][27:24]; na = VEC[v][7:4]; ee = VEC[v][3:0];
      do_reset();
      mode = m; link_mask = mk; ack_timeout = VEC[v][23:16];
      dly = int'(VEC[v][15:8]); noack = na; rdy = '1;
      clear_rec();
      pulse(m[1]);
      wait_done();
      chk(link_err == ee, "R8 link_err after dispatch", link_err, ee);
      chk(ltick_cnt == 1, m[1] ? "R3 single local tick" : "R2 single local tick", ltick_cnt, 1);
      chk(hs_acc == mk, "R4 every masked link served", hs_acc, mk);
      if (m == 2'd2) begin
        chk(first_cnt == $countones(mk), "R3 relay offers all children at once", first_cnt, $countones(mk));
      end else begin
        chk(order_ok, "R4 lowest index first", order_ok, 1);
        chk(hs_cnt == $countones(mk), "R4 one handshake per link", hs_cnt, $countones(mk));
      end
      if (m == 2'd0 && mk != 0)
        chk(max_out <= 1, "R6 stop-and-wait outstanding", max_out, 1);
      if (m == 2'd1 && na == 0)
        chk(max_out == $countones(mk), "R7 round-robin outstanding", max_out, $countones(mk));
      if (mk == 0)
        chk(busy == 0 && overrun == 0, "R10 empty mask stays idle", busy, 0);
    end

    // master mode ignores the relay trigger
    do_reset();
    mode = 2'd0; link_mask = 4'b0001; noack = '0; dly = 0; clear_rec();
    pulse(1'b1); repeat (4) @(negedge clk);
    chk(ltick_cnt == 0 && hs_acc == 0 && busy == 0, "R2 parent_tick ignored in master", ltick_cnt, 0);

    // relay mode ignores the timer trigger
    mode = 2'd2; clear_rec();
    pulse(1'b0); repeat (4) @(negedge clk);
    chk(ltick_cnt == 0 && hs_acc == 0 && busy == 0, "R3 timer_ovf ignored in relay", ltick_cnt, 0);

    // backpressure: valid held while ready is low
    do_reset();
    mode = 2'd0; link_mask = 4'b0010; ack_timeout = 8'd4; rdy = '0; clear_rec();
    pulse(1'b0);
    for (int i = 0; i < 4; i++) begin
      chk(tick_out_valid == 4'b0010, "R5 valid held without ready", tick_out_valid, 4'b0010);
      @(negedge clk);
    end
    chk(hs_acc == 0, "R5 no handshake while not ready", hs_acc, 0);
    rdy = '1;
    wait_done();
    chk(hs_acc == 4'b0010 && link_err == 0, "R5 handshake after ready", {hs_acc, link_err}, 8'h20);
    chk(tick_out_valid == 0, "R5 valid drops after handshake", tick_out_valid, 0);

    // overrun: second overflow during dispatch is dropped
    do_reset();
    mode = 2'd0; link_mask = 4'b0011; ack_timeout = 8'd8; dly = 3; rdy = '1; clear_rec();
    pulse(1'b0);
    pulse(1'b0);
    chk(overrun == 1, "R9 overrun set", overrun, 1);
    wait_done();
    chk(ltick_cnt == 1 && hs_cnt == 2, "R9 dropped tick not queued", hs_cnt, 2);
    clear_rec();
    pulse(1'b0);
    wait_done();
    chk(overrun == 1 && hs_cnt == 2, "R9 overrun sticky, next tick served", {overrun, 4'(hs_cnt)}, 5'h12);

    // error flags survive a clean dispatch
    do_reset();
    mode = 2'd0; link_mask = 4'b0001; ack_timeout = 8'd2; noack = 4'b0001; dly = 0; clear_rec();
    pulse(1'b0); wait_done();
    chk(link_err == 4'b0001, "R8 timeout sets error", link_err, 1);
    noack = '0; clear_rec();
    pulse(1'b0); wait_done();
    chk(link_err == 4'b0001 && hs_acc == 4'b0001, "R10 error sticky", link_err, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule